// File: doc/BRIEF.md
# Padded 2D Tile Load Sequencer

This block expands a single tile-move command into a stream of element reads from external memory and element writes into a local buffer. The tile is a rectangle of `rows_i` rows by `cols_i` columns taken from external memory. Consecutive rows start `stride_i` elements apart. On the fly the block surrounds the rectangle with zero elements: whole zero rows above and below, and zero elements to the left and right of every row. Each of the four margins has its own amount.

A command is presented with a one-cycle `start_i` while the block is idle. The block then walks the padded tile in row-major order, one position per step. A padding position becomes a zero write at once and touches no external memory. A data position raises a read request and waits until the memory accepts it. The memory returns the element in the accepting cycle, and that element becomes the local write on the next cycle. Local writes fill consecutive addresses from the local base, so the stored row pitch is the left margin plus the column count plus the right margin. The memory-select code captured from the command travels with every write and steers it to the right local buffer.

Top module: `lg_pad_loader`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `rd_valid_o`, `wr_valid_o` and `done_o` are 0 until a command is accepted.
- R2: An accepted command produces exactly (pad_top+rows+pad_bot)*(pad_left+cols+pad_right) local writes, in row-major order of the padded tile, at addresses loc_base, loc_base+1, and so on in order.
- R3: A write at a padding position (row index < pad_top, or row index >= pad_top+rows, or column index < pad_left, or column index >= pad_left+cols) has `wr_zero_o`=1 and `wr_data_o`=0, and no read request is raised for it.
- R4: The data element at tile row r and column c (both counted from 0 inside the unpadded rectangle) is requested at `rd_addr_o` = ext_base + r*stride + c, and read requests follow row-major order.
- R5: The write for a data position has `wr_zero_o`=0 and carries the `rd_data_i` value present in the cycle where `rd_valid_o` and `rd_ready_i` were both 1. It appears one cycle after that cycle.
- R6: While `rd_valid_o` is 1 and `rd_ready_i` is 0, the request stays raised with an unchanged address, and the walk does not advance.
- R7: `done_o` is a one-cycle pulse. It rises with the final write of the command, and `busy_o` is 0 in that cycle.
- R8: If rows or cols is 0, only zero writes are produced and no reads are made. If the padded tile is empty, no write occurs and `done_o` pulses one cycle after `start_i`.
- R9: A `start_i` that arrives while `busy_o` is 1 is ignored: the running command's writes and reads are unchanged.
- R10: Every write of a command carries on `wr_sel_o` the `mem_sel_i` value captured when that command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| mem_sel_i | input | SELW | Target local buffer code |
| loc_base_i | input | LOC_AW | First local write address |
| ext_base_i | input | EXT_AW | External address of the first data element |
| rows_i | input | SZW | Data rows in the tile |
| cols_i | input | SZW | Data elements per row |
| stride_i | input | STW | External element distance between row starts |
| pad_top_i | input | PADW | Zero rows before the tile |
| pad_bot_i | input | PADW | Zero rows after the tile |
| pad_left_i | input | PADW | Zero elements at the start of each row |
| pad_right_i | input | PADW | Zero elements at the end of each row |
| busy_o | output | 1 | A command is being walked |
| rd_valid_o | output | 1 | External read request |
| rd_ready_i | input | 1 | External memory accepts the request |
| rd_addr_o | output | EXT_AW | External element address |
| rd_data_i | input | DW | Element returned in the accepting cycle |
| wr_valid_o | output | 1 | Local write strobe |
| wr_sel_o | output | SELW | Local buffer code of the write |
| wr_addr_o | output | LOC_AW | Local write address |
| wr_data_o | output | DW | Local write data |
| wr_zero_o | output | 1 | Write is padding fill |
| done_o | output | 1 | Command finished pulse |

## Verification
The walk is tried on a square window with a margin of one on every side, on a tile with lopsided margins, on a tile with no margins, and on a tile with a large stride from a high external base. Taken together these tell a correct row pitch and row step apart from off-by-one errors in either margin, and apart from a stride applied to padded rows. The same shapes are run with a memory that always accepts, one that accepts every other cycle and one that accepts at pseudo-random cycles; this separates a correct stall from a skipped or repeated element. Degenerate tiles with zero rows, zero columns or no elements at all are run to check the padding-only and empty-tile paths. A second strobe sent in the middle of a command checks that it is ignored.

// File: rtl/lg_pkg.sv
package lg_pkg;
    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } wk_state_e;
endpackage

// File: rtl/lg_walker.sv
module lg_walker
    import lg_pkg::*;
#(
    parameter int SZW  = 8,
    parameter int PADW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [SZW-1:0]  rows_i,
    input  logic [SZW-1:0]  cols_i,
    input  logic [PADW-1:0] pad_top_i,
    input  logic [PADW-1:0] pad_bot_i,
    input  logic [PADW-1:0] pad_left_i,
    input  logic [PADW-1:0] pad_right_i,
    input  logic            step_i,
    output logic            active_o,
    output logic            pad_o,
    output logic            data_row_o,
    output logic            row_end_o,
    output logic            last_o,
    output logic            empty_o
);
    localparam int CW = ((SZW > PADW) ? SZW : PADW) + 2;

    typedef struct packed {
        wk_state_e     st;
        logic [CW-1:0] r;
        logic [CW-1:0] c;
        logic [CW-1:0] row_lo;
        logic [CW-1:0] row_hi;
        logic [CW-1:0] col_lo;
        logic [CW-1:0] col_hi;
        logic [CW-1:0] row_n;
        logic [CW-1:0] col_n;
    } walk_t;

    walk_t w_d, w_q;
    logic [CW-1:0] tot_r, tot_c;

    always_comb begin
        tot_r = CW'(pad_top_i) + CW'(rows_i) + CW'(pad_bot_i);
        tot_c = CW'(pad_left_i) + CW'(cols_i) + CW'(pad_right_i);
        empty_o = (tot_r == '0) || (tot_c == '0);

        active_o   = (w_q.st == WK_RUN);
        data_row_o = (w_q.r >= w_q.row_lo) && (w_q.r < w_q.row_hi);
        pad_o      = !data_row_o || (w_q.c < w_q.col_lo) || (w_q.c >= w_q.col_hi);
        row_end_o  = (w_q.c == w_q.col_n - 1'b1);
        last_o     = row_end_o && (w_q.r == w_q.row_n - 1'b1);

        w_d = w_q;
        if (w_q.st == WK_IDLE) begin
            if (start_i && !empty_o) begin
                w_d.st     = WK_RUN;
                w_d.r      = '0;
                w_d.c      = '0;
                w_d.row_lo = CW'(pad_top_i);
                w_d.row_hi = CW'(pad_top_i) + CW'(rows_i);
                w_d.col_lo = CW'(pad_left_i);
                w_d.col_hi = CW'(pad_left_i) + CW'(cols_i);
                w_d.row_n  = tot_r;
                w_d.col_n  = tot_c;
            end
        end else if (step_i) begin
            if (row_end_o) begin
                w_d.c = '0;
                if (last_o) begin
                    w_d.st = WK_IDLE;
                end else begin
                    w_d.r = w_q.r + 1'b1;
                end
            end else begin
                w_d.c = w_q.c + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    // R2: the walk position never leaves the padded tile
    assert_pos_in_tile_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (w_q.r < w_q.row_n) && (w_q.c < w_q.col_n));

    // R6: a position that did not step is held
    assert_hold_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && !step_i |=> $stable(w_q.r) && $stable(w_q.c));
endmodule

// File: rtl/lg_addr.sv
module lg_addr #(
    parameter int EXT_AW = 32,
    parameter int LOC_AW = 16,
    parameter int STW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [EXT_AW-1:0] ext_base_i,
    input  logic [LOC_AW-1:0] loc_base_i,
    input  logic [STW-1:0]    stride_i,
    input  logic              step_i,
    input  logic              pad_i,
    input  logic              row_end_i,
    input  logic              data_row_i,
    output logic [EXT_AW-1:0] ext_addr_o,
    output logic [LOC_AW-1:0] loc_addr_o
);
    typedef struct packed {
        logic [EXT_AW-1:0] ext_row;
        logic [EXT_AW-1:0] ext_ptr;
        logic [EXT_AW-1:0] stride;
        logic [LOC_AW-1:0] loc;
    } addr_t;

    addr_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (load_i) begin
            a_d.ext_row = ext_base_i;
            a_d.ext_ptr = ext_base_i;
            a_d.stride  = EXT_AW'(stride_i);
            a_d.loc     = loc_base_i;
        end else if (step_i) begin
            a_d.loc = a_q.loc + 1'b1;
            if (row_end_i) begin
                if (data_row_i) begin
                    a_d.ext_row = a_q.ext_row + a_q.stride;
                    a_d.ext_ptr = a_q.ext_row + a_q.stride;
                end else begin
                    a_d.ext_ptr = a_q.ext_row;
                end
            end else if (!pad_i) begin
                a_d.ext_ptr = a_q.ext_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign ext_addr_o = a_q.ext_ptr;
    assign loc_addr_o = a_q.loc;

    // R2: local addressing starts at the commanded base
    assert_loc_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> loc_addr_o == $past(loc_base_i));

    // R4: external addressing starts at the commanded base
    assert_ext_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ext_addr_o == $past(ext_base_i));
endmodule

// File: rtl/lg_pad_loader.sv
module lg_pad_loader #(
    parameter int EXT_AW = 32,
    parameter int LOC_AW = 16,
    parameter int DW     = 32,
    parameter int SZW    = 8,
    parameter int PADW   = 4,
    parameter int STW    = 16,
    parameter int SELW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SELW-1:0]   mem_sel_i,
    input  logic [LOC_AW-1:0] loc_base_i,
    input  logic [EXT_AW-1:0] ext_base_i,
    input  logic [SZW-1:0]    rows_i,
    input  logic [SZW-1:0]    cols_i,
    input  logic [STW-1:0]    stride_i,
    input  logic [PADW-1:0]   pad_top_i,
    input  logic [PADW-1:0]   pad_bot_i,
    input  logic [PADW-1:0]   pad_left_i,
    input  logic [PADW-1:0]   pad_right_i,
    output logic              busy_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [EXT_AW-1:0] rd_addr_o,
    input  logic [DW-1:0]     rd_data_i,
    output logic              wr_valid_o,
    output logic [SELW-1:0]   wr_sel_o,
    output logic [LOC_AW-1:0] wr_addr_o,
    output logic [DW-1:0]     wr_data_o,
    output logic              wr_zero_o,
    output logic              done_o
);
    typedef struct packed {
        logic              wr_valid;
        logic [LOC_AW-1:0] wr_addr;
        logic [DW-1:0]     wr_data;
        logic              wr_zero;
        logic [SELW-1:0]   sel;
        logic              done;
    } out_t;

    out_t o_d, o_q;

    logic active, pad, data_row, row_end, last, empty;
    logic step, accept, accept_empty;
    logic [LOC_AW-1:0] loc_addr;

    lg_walker #(.SZW(SZW), .PADW(PADW)) walker_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rows_i      (rows_i),
        .cols_i      (cols_i),
        .pad_top_i   (pad_top_i),
        .pad_bot_i   (pad_bot_i),
        .pad_left_i  (pad_left_i),
        .pad_right_i (pad_right_i),
        .step_i      (step),
        .active_o    (active),
        .pad_o       (pad),
        .data_row_o  (data_row),
        .row_end_o   (row_end),
        .last_o      (last),
        .empty_o     (empty)
    );

    lg_addr #(.EXT_AW(EXT_AW), .LOC_AW(LOC_AW), .STW(STW)) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .ext_base_i (ext_base_i),
        .loc_base_i (loc_base_i),
        .stride_i   (stride_i),
        .step_i     (step),
        .pad_i      (pad),
        .row_end_i  (row_end),
        .data_row_i (data_row),
        .ext_addr_o (rd_addr_o),
        .loc_addr_o (loc_addr)
    );

    always_comb begin
        accept       = start_i && !active && !empty;
        accept_empty = start_i && !active && empty;
        rd_valid_o   = active && !pad;
        step         = active && (pad || rd_ready_i);

        o_d          = o_q;
        o_d.wr_valid = step;
        o_d.wr_addr  = loc_addr;
        o_d.wr_zero  = pad;
        o_d.wr_data  = pad ? '0 : rd_data_i;
        o_d.done     = (step && last) || accept_empty;
        if (accept) begin
            o_d.sel = mem_sel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign busy_o     = active;
    assign wr_valid_o = o_q.wr_valid;
    assign wr_sel_o   = o_q.sel;
    assign wr_addr_o  = o_q.wr_addr;
    assign wr_data_o  = o_q.wr_data;
    assign wr_zero_o  = o_q.wr_zero;
    assign done_o     = o_q.done;

    // R5: a non-zero write follows an accepted read by one cycle
    assert_fetch_backs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_zero_o |-> $past(rd_valid_o && rd_ready_i));

    // R6: a stalled request keeps its address
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

    // R7: completion is seen with the walker idle and lasts one cycle
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: writes only follow a cycle of walking
    assert_write_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> $past(busy_o));
endmodule

// File: tb/lg_pad_loader_tb_top.sv
module lg_pad_loader_tb_top;
    localparam int EXT_AW = 32;
    localparam int LOC_AW = 16;
    localparam int DW     = 32;
    localparam int SZW    = 8;
    localparam int PADW   = 4;
    localparam int STW    = 16;
    localparam int SELW   = 3;

    typedef struct packed {
        logic [LOC_AW-1:0] addr;
        logic [DW-1:0]     data;
        logic              zero;
        logic [SELW-1:0]   sel;
    } wr_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [SELW-1:0]   mem_sel_i = '0;
    logic [LOC_AW-1:0] loc_base_i = '0;
    logic [EXT_AW-1:0] ext_base_i = '0;
    logic [SZW-1:0]    rows_i = '0, cols_i = '0;
    logic [STW-1:0]    stride_i = '0;
    logic [PADW-1:0]   pad_top_i = '0, pad_bot_i = '0, pad_left_i = '0, pad_right_i = '0;
    logic busy_o, rd_valid_o, wr_valid_o, wr_zero_o, done_o;
    logic rd_ready_i = 1'b0;
    logic [EXT_AW-1:0] rd_addr_o;
    logic [DW-1:0]     rd_data_i;
    logic [SELW-1:0]   wr_sel_o;
    logic [LOC_AW-1:0] wr_addr_o;
    logic [DW-1:0]     wr_data_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA7;
    logic stall_prev = 1'b0;
    logic [EXT_AW-1:0] stall_addr = '0;

    logic [EXT_AW-1:0] exp_rd[$];
    wr_item_t exp_wr[$];

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mem_val(input logic [EXT_AW-1:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    assign rd_data_i = mem_val(rd_addr_o);

    lg_pad_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_sel_i(mem_sel_i),
        .loc_base_i(loc_base_i), .ext_base_i(ext_base_i), .rows_i(rows_i),
        .cols_i(cols_i), .stride_i(stride_i), .pad_top_i(pad_top_i),
        .pad_bot_i(pad_bot_i), .pad_left_i(pad_left_i), .pad_right_i(pad_right_i),
        .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .wr_valid_o(wr_valid_o),
        .wr_sel_o(wr_sel_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_zero_o(wr_zero_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: sets ready, then compares handshakes and writes
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rdy_mode)
                0: rd_ready_i = 1'b1;
                1: rd_ready_i = ~rd_ready_i;
                default: rd_ready_i = lfsr[0];
            endcase
            if (stall_prev) begin
                chk(rd_valid_o && rd_addr_o == stall_addr, "R6 held request", 64'(rd_addr_o), 64'(stall_addr));
            end
            stall_prev = rd_valid_o && !rd_ready_i;
            stall_addr = rd_addr_o;
            if (rd_valid_o && rd_ready_i) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R3/R8 unexpected read", 64'(rd_addr_o), 64'd0);
                end else begin
                    logic [EXT_AW-1:0] ea;
                    ea = exp_rd.pop_front();
                    chk(rd_addr_o == ea, "R4 read address", 64'(rd_addr_o), 64'(ea));
                end
            end
            if (wr_valid_o) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R2 unexpected write", 64'(wr_addr_o), 64'd0);
                end else begin
                    wr_item_t e;
                    e = exp_wr.pop_front();
                    chk(wr_addr_o == e.addr, "R2 write address", 64'(wr_addr_o), 64'(e.addr));
                    chk(wr_zero_o == e.zero, "R3 zero flag", 64'(wr_zero_o), 64'(e.zero));
                    chk(wr_data_o == e.data, e.zero ? "R3 zero data" : "R5 fetched data",
                        64'(wr_data_o), 64'(e.data));
                    chk(wr_sel_o == e.sel, "R10 buffer select", 64'(wr_sel_o), 64'(e.sel));
                end
            end
        end
    end

    // driver: pushes expected items, launches the command, waits for done
    task automatic run_cmd(input int sel, input int lb, input int eb, input int rows, input int cols,
                           input int stride, input int pt, input int pb, input int pl, input int pr,
                           input int mode, input bit poke);
        int tr, tc, idx, cyc, nwr;
        tr = pt + rows + pb;
        tc = pl + cols + pr;
        idx = 0;
        for (int r = 0; r < tr; r++) begin
            for (int c = 0; c < tc; c++) begin
                wr_item_t it;
                it.addr = LOC_AW'(lb + idx);
                it.sel  = SELW'(sel);
                if (r >= pt && r < pt + rows && c >= pl && c < pl + cols) begin
                    logic [EXT_AW-1:0] ea;
                    ea = EXT_AW'(eb) + EXT_AW'((r - pt) * stride) + EXT_AW'(c - pl);
                    exp_rd.push_back(ea);
                    it.data = mem_val(ea);
                    it.zero = 1'b0;
                end else begin
                    it.data = '0;
                    it.zero = 1'b1;
                end
                exp_wr.push_back(it);
                idx++;
            end
        end
        nwr = idx;
        @(negedge clk);
        rdy_mode   = mode;
        mem_sel_i  = SELW'(sel);
        loc_base_i = LOC_AW'(lb);
        ext_base_i = EXT_AW'(eb);
        rows_i = SZW'(rows); cols_i = SZW'(cols); stride_i = STW'(stride);
        pad_top_i = PADW'(pt); pad_bot_i = PADW'(pb); pad_left_i = PADW'(pl); pad_right_i = PADW'(pr);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 5000) begin
            if (poke && cyc == 3) begin
                // R9: a second strobe with other fields while busy
                chk(busy_o == 1'b1, "R9 busy before poke", 64'(busy_o), 64'd1);
                mem_sel_i = ~mem_sel_i; loc_base_i = 16'h7777; ext_base_i = 32'h1234;
                rows_i = 8'd1; cols_i = 8'd1; pad_top_i = '0; pad_left_i = '0;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R7 done seen", 64'(done_o), 64'd1);
        chk(busy_o == 1'b0, "R7 idle at done", 64'(busy_o), 64'd0);
        if (nwr == 0) begin
            chk(cyc == 0, "R8 empty tile done latency", 64'(cyc), 64'd0);
            chk(wr_valid_o == 1'b0, "R8 no write", 64'(wr_valid_o), 64'd0);
        end else begin
            chk(wr_valid_o == 1'b1, "R7 done with last write", 64'(wr_valid_o), 64'd1);
        end
        #1;
        chk(exp_wr.size() == 0, "R2 all writes seen", 64'(exp_wr.size()), 64'd0);
        chk(exp_rd.size() == 0, "R4 all reads seen", 64'(exp_rd.size()), 64'd0);
        exp_wr.delete();
        exp_rd.delete();
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", 64'(done_o), 64'd0);
        chk(wr_valid_o == 1'b0, "R9 no writes after done", 64'(wr_valid_o), 64'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk(!busy_o && !rd_valid_o && !wr_valid_o && !done_o, "R1 reset outputs",
                64'({busy_o, rd_valid_o, wr_valid_o, done_o}), 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !rd_valid_o && !wr_valid_o && !done_o, "R1 idle after reset",
            64'({busy_o, rd_valid_o, wr_valid_o, done_o}), 64'd0);

        // R2 R3 R4: square window, unit margins, always ready
        run_cmd(2, 16'h0100, 32'h1000, 4, 4, 16, 1, 1, 1, 1, 0, 1'b0);
        // R3 R4: lopsided margins, alternating ready
        run_cmd(5, 16'h0040, 32'h2000, 3, 5, 7, 0, 2, 3, 0, 1, 1'b0);
        // R5 R6: no margins, random ready
        run_cmd(1, 16'h0000, 32'h3000, 2, 3, 3, 0, 0, 0, 0, 2, 1'b0);
        // R4 R6: high base, large stride, random ready
        run_cmd(7, 16'hFFF0, 32'hFFFF_0000, 3, 2, 1000, 2, 0, 0, 1, 2, 1'b0);
        // R8: zero rows, only margins
        run_cmd(3, 16'h0200, 32'h4000, 0, 3, 5, 2, 1, 1, 1, 0, 1'b0);
        // R8: zero columns
        run_cmd(4, 16'h0300, 32'h5000, 2, 0, 5, 1, 0, 1, 2, 1, 1'b0);
        // R8: empty padded tile
        run_cmd(6, 16'h0400, 32'h6000, 0, 0, 0, 0, 0, 3, 2, 0, 1'b0);
        // R9: strobe while busy is ignored
        run_cmd(2, 16'h0500, 32'h7000, 3, 3, 8, 1, 0, 0, 1, 1, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule